// File: doc/BRIEF.md
# Accumulator Machine Instruction Sequencer

This block is the multi-cycle control core of a small 12-bit processor with one accumulator and a one-bit link that sits above the accumulator's top bit as a carry extension. It owns the program counter, the instruction register, the accumulator, the link and the run flag. It drives a synchronous single-port memory. Each pass of its loop fetches a word, advances the program counter, and then carries out the instruction that the top three bits of the word select.

Two neighbours finish the processor. An address unit forms the effective address from the instruction register and program counter, both of which the sequencer exposes. An operate-group unit takes all opcode-7 work: it returns a new accumulator, a new link, a skip flag and a halt flag. The sequencer executes the six memory-reference opcodes and the device-pulse opcode itself. The memory port has no handshake. Reads take exactly one cycle, writes complete in the cycle they are presented, and the memory may never stall the sequencer. The neighbour interfaces are combinational and are sampled in fixed states. Bit indices below count from the least significant bit: the opcode is IR[11:9].

Top module: `acc_seq_core`

## Requirements
- R1: After reset the run flag, program counter, accumulator and link are all 0 and no memory write occurs. While stopped with start low, none of these change.
- R2: When start is high while stopped, the next cycle shows the run flag set and the program counter equal to start_addr. Start is ignored while running.
- R3: Each instruction reads memory at the program counter one cycle before the word is captured into IR, and the program counter then advances by one. A program that halts at address h leaves the program counter at h+1.
- R4: Opcode 0 replaces the accumulator with the accumulator ANDed with the memory word at the effective address. The link is unchanged.
- R5: Opcode 1 adds the memory word at the effective address into the 13-bit value {link, accumulator}, modulo 2^13, so that the carry out of the accumulator toggles into the link.
- R6: Opcode 2 writes back the memory word at the effective address plus one, modulo 4096. If the written value is zero, the next instruction is skipped.
- R7: Opcode 3 stores the accumulator at the effective address and leaves the accumulator at zero.
- R8: Opcode 4 stores the address of the following instruction at the effective address and continues execution at the effective address plus one.
- R9: Opcode 5 continues execution at the effective address with no memory write.
- R10: Opcode 6 spends three consecutive pulse slots, checked in the order IR[0], IR[1], IR[2]. A one-cycle pulse appears on io_pulse[k] in slot k only if IR[k] is 1, and at most one pulse line is high at a time. io_sel carries IR[8:3] during every pulse.
- R11: Opcode 7 raises opr_valid for one cycle and takes opr_ac_new and opr_link_new. It skips the next instruction when opr_skip is 1. When opr_halt is 1 it clears the run flag at the end of the instruction, and it never writes memory.
- R12: Every memory write lasts exactly one cycle, and each instruction writes memory at most once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin execution (honoured only while stopped) |
| start_addr | input | 12 | First instruction address |
| mem_addr | output | 12 | Memory address |
| mem_wdata | output | 12 | Memory write data |
| mem_we | output | 1 | Memory write enable |
| mem_rdata | input | 12 | Memory read data, one cycle after address |
| ea_addr | input | 12 | Effective address from the address unit |
| opr_valid | output | 1 | Operate-group instruction in execution |
| opr_ac_new | input | 12 | Accumulator result from the operate unit |
| opr_link_new | input | 1 | Link result from the operate unit |
| opr_skip | input | 1 | Operate unit requests a skip |
| opr_halt | input | 1 | Operate unit requests a halt |
| io_sel | output | 6 | Device select during pulses |
| io_pulse | output | 3 | Device pulses |
| ir_o | output | 12 | Instruction register |
| pc_o | output | 12 | Program counter |
| ac_o | output | 12 | Accumulator |
| link_o | output | 1 | Link bit |
| run_o | output | 1 | Run flag |

## Verification
The two hardest situations to reach from the ports are the skip taken by opcode 2 and the relative timing of the device pulses. The skip only happens when a memory word wraps from 4095 to zero. To reach it, the stimulus sweeps a set of operand words that includes 4095 and places a marker instruction after the increment, so the accumulator shows whether the skip was taken. For the pulses, every one of the eight pulse-enable patterns is run. Each observed pulse is logged with its cycle, so that the order, the slot spacing and the suppressed slots can all be checked against the pattern. The add and AND opcodes are swept over a grid of operand pairs that reaches carries into the link.

// File: rtl/acc_seq_pkg.sv
package acc_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_DECODE,
    ST_ADDR,
    ST_READ,
    ST_EXEC,
    ST_WBACK
  } seq_state_t;

  localparam logic [2:0] OP_AND  = 3'd0;
  localparam logic [2:0] OP_ADD  = 3'd1;
  localparam logic [2:0] OP_ISZ  = 3'd2;
  localparam logic [2:0] OP_DEP  = 3'd3;
  localparam logic [2:0] OP_CALL = 3'd4;
  localparam logic [2:0] OP_JUMP = 3'd5;
  localparam logic [2:0] OP_IOP  = 3'd6;
  localparam logic [2:0] OP_OPR  = 3'd7;

endpackage

// File: rtl/acc_seq_fsm.sv
module acc_seq_fsm
  import acc_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [2:0] op,
  input  logic       pulse_done,
  input  logic       halt_now,
  output seq_state_t state
);

  seq_state_t nxt;
  seq_state_t done_to;

  // where an instruction goes when it finishes
  assign done_to = halt_now ? ST_IDLE : ST_FETCH;

  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE:   if (start) nxt = ST_FETCH;
      ST_FETCH:  nxt = ST_DECODE;
      ST_DECODE: nxt = ST_ADDR;
      ST_ADDR: begin
        case (op)
          OP_AND, OP_ADD, OP_ISZ: nxt = ST_READ;
          OP_DEP, OP_CALL:        nxt = ST_WBACK;
          default:                nxt = ST_EXEC;
        endcase
      end
      ST_READ:   nxt = ST_EXEC;
      ST_EXEC: begin
        if (op == OP_ISZ)      nxt = ST_WBACK;
        else if (op == OP_IOP) nxt = pulse_done ? ST_FETCH : ST_EXEC;
        else                   nxt = done_to;
      end
      ST_WBACK:  nxt = ST_FETCH;
      default:   nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end

endmodule

// File: rtl/acc_seq_alu.sv
module acc_seq_alu #(
  parameter int W = 12
) (
  input  logic [W-1:0] ac,
  input  logic         link,
  input  logic [W-1:0] mword,
  output logic [W-1:0] and_res,
  output logic [W:0]   sum_res,
  output logic [W-1:0] inc_res
);

  assign and_res = ac & mword;
  assign sum_res = {link, ac} + {1'b0, mword};
  assign inc_res = mword + W'(1);

endmodule

// File: rtl/acc_seq_pulse.sv
module acc_seq_pulse #(
  parameter int NPULSE = 3,
  parameter int SELW   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic [NPULSE-1:0] enables,
  input  logic [SELW-1:0]   sel_in,
  output logic [NPULSE-1:0] pulse,
  output logic [SELW-1:0]   sel,
  output logic              done
);

  localparam int CW = (NPULSE > 1) ? $clog2(NPULSE) : 1;

  logic [CW-1:0] slot_q;

  assign done = active && (slot_q == CW'(NPULSE - 1));
  assign sel  = active ? sel_in : '0;

  for (genvar k = 0; k < NPULSE; k++) begin : g_slot
    assign pulse[k] = active && (slot_q == CW'(k)) && enables[k];
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !active) slot_q <= '0;
    else if (!done)        slot_q <= slot_q + CW'(1);
  end

endmodule

// File: rtl/acc_seq_core.sv
module acc_seq_core
  import acc_seq_pkg::*;
#(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] start_addr,
  output logic [W-1:0] mem_addr,
  output logic [W-1:0] mem_wdata,
  output logic         mem_we,
  input  logic [W-1:0] mem_rdata,
  input  logic [W-1:0] ea_addr,
  output logic         opr_valid,
  input  logic [W-1:0] opr_ac_new,
  input  logic         opr_link_new,
  input  logic         opr_skip,
  input  logic         opr_halt,
  output logic [5:0]   io_sel,
  output logic [2:0]   io_pulse,
  output logic [W-1:0] ir_o,
  output logic [W-1:0] pc_o,
  output logic [W-1:0] ac_o,
  output logic         link_o,
  output logic         run_o
);

  localparam int OPW    = 3;
  localparam int NPULSE = 3;
  localparam int SELW   = W - OPW - NPULSE;

  seq_state_t     state;
  logic [W-1:0]   pc_q, ac_q, ir_q, ea_q, tmp_q;
  logic           link_q, run_q;
  logic [OPW-1:0] op;
  logic [W-1:0]   and_res, inc_res;
  logic [W:0]     sum_res;
  logic           pulse_active, pulse_done, halt_now;

  assign op           = ir_q[W-1 -: OPW];
  assign pulse_active = (state == ST_EXEC) && (op == OP_IOP);
  assign opr_valid    = (state == ST_EXEC) && (op == OP_OPR);
  assign halt_now     = opr_valid && opr_halt;

  acc_seq_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .op         (op),
    .pulse_done (pulse_done),
    .halt_now   (halt_now),
    .state      (state)
  );

  acc_seq_alu #(.W(W)) u_alu (
    .ac      (ac_q),
    .link    (link_q),
    .mword   (mem_rdata),
    .and_res (and_res),
    .sum_res (sum_res),
    .inc_res (inc_res)
  );

  acc_seq_pulse #(.NPULSE(NPULSE), .SELW(SELW)) u_pulse (
    .clk     (clk),
    .rst_n   (rst_n),
    .active  (pulse_active),
    .enables (ir_q[NPULSE-1:0]),
    .sel_in  (ir_q[NPULSE+SELW-1:NPULSE]),
    .pulse   (io_pulse),
    .sel     (io_sel),
    .done    (pulse_done)
  );

  // memory port
  always_comb begin
    case (state)
      ST_READ, ST_WBACK: mem_addr = ea_q;
      default:           mem_addr = pc_q;
    endcase
  end

  assign mem_we = (state == ST_WBACK);

  always_comb begin
    case (op)
      OP_ISZ:  mem_wdata = tmp_q;
      OP_CALL: mem_wdata = pc_q;
      default: mem_wdata = ac_q;
    endcase
  end

  // architectural registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q   <= '0;
      ac_q   <= '0;
      ir_q   <= '0;
      ea_q   <= '0;
      tmp_q  <= '0;
      link_q <= 1'b0;
      run_q  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            pc_q  <= start_addr;
            run_q <= 1'b1;
          end
        end
        ST_DECODE: begin
          ir_q <= mem_rdata;
          pc_q <= pc_q + W'(1);
        end
        ST_ADDR: ea_q <= ea_addr;
        ST_EXEC: begin
          case (op)
            OP_AND:  ac_q <= and_res;
            OP_ADD:  {link_q, ac_q} <= sum_res;
            OP_ISZ:  tmp_q <= inc_res;
            OP_JUMP: pc_q <= ea_q;
            OP_OPR: begin
              ac_q   <= opr_ac_new;
              link_q <= opr_link_new;
              if (opr_skip) pc_q <= pc_q + W'(1);
              if (opr_halt) run_q <= 1'b0;
            end
            default: ;
          endcase
        end
        ST_WBACK: begin
          case (op)
            OP_ISZ:  if (tmp_q == '0) pc_q <= pc_q + W'(1);
            OP_DEP:  ac_q <= '0;
            OP_CALL: pc_q <= ea_q + W'(1);
            default: ;
          endcase
        end
        default: ;
      endcase
    end
  end

  assign ir_o   = ir_q;
  assign pc_o   = pc_q;
  assign ac_o   = ac_q;
  assign link_o = link_q;
  assign run_o  = run_q;

endmodule

// File: rtl/acc_seq_checker.sv
module acc_seq_checker #(
  parameter int W = 12
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic [W-1:0] start_addr,
  input logic         mem_we,
  input logic         run_o,
  input logic [W-1:0] pc_o,
  input logic [2:0]   io_pulse,
  input logic         opr_valid,
  input logic         opr_halt
);

  assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_o && !start) |=> (!run_o && $stable(pc_o)));

  assert_idle_no_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !run_o |-> !mem_we);

  assert_start_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !run_o) |=> (run_o && pc_o == $past(start_addr)));

  assert_pulse_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(io_pulse));

  assert_opr_no_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    opr_valid |-> !mem_we);

  assert_halt_stops_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (opr_valid && opr_halt) |=> !run_o);

  assert_write_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);

endmodule

bind acc_seq_core acc_seq_checker #(.W(W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .start_addr (start_addr),
  .mem_we     (mem_we),
  .run_o      (run_o),
  .pc_o       (pc_o),
  .io_pulse   (io_pulse),
  .opr_valid  (opr_valid),
  .opr_halt   (opr_halt)
);

// File: tb/acc_seq_core_test.sv
module acc_seq_core_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [11:0] start_addr = '0;
  logic [11:0] mem_addr, mem_wdata, mem_rdata, ea_addr;
  logic        mem_we, opr_valid;
  logic [11:0] opr_ac_new;
  logic        opr_link_new, opr_skip, opr_halt;
  logic [5:0]  io_sel;
  logic [2:0]  io_pulse;
  logic [11:0] ir_o, pc_o, ac_o;
  logic        link_o, run_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_seq_core uut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_rdata(mem_rdata),
    .ea_addr(ea_addr), .opr_valid(opr_valid), .opr_ac_new(opr_ac_new),
    .opr_link_new(opr_link_new), .opr_skip(opr_skip), .opr_halt(opr_halt),
    .io_sel(io_sel), .io_pulse(io_pulse), .ir_o(ir_o), .pc_o(pc_o), .ac_o(ac_o),
    .link_o(link_o), .run_o(run_o)
  );

  // behavioural memory (256 words, address wraps), with a bench load port
  logic [11:0] mem [256];
  logic        tb_we = 1'b0;
  logic [7:0]  tb_addr = '0;
  logic [11:0] tb_data = '0;

  always @(posedge clk) begin
    mem_rdata <= mem[mem_addr[7:0]];
    if (tb_we)       mem[tb_addr] <= tb_data;
    else if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
  end

  // address unit: page-zero or current-page direct addressing
  assign ea_addr = ir_o[7] ? {pc_o[11:7], ir_o[6:0]} : {5'd0, ir_o[6:0]};

  // operate unit: bit7 clears AC, bit3 skips, bit1 halts
  assign opr_ac_new   = ir_o[7] ? 12'd0 : ac_o;
  assign opr_link_new = link_o;
  assign opr_skip     = ir_o[3];
  assign opr_halt     = ir_o[1];

  localparam logic [11:0] W_HALT = 12'o7402;
  localparam logic [11:0] W_CLA  = 12'o7200;
  localparam logic [11:0] W_SKIP = 12'o7010;

  function automatic logic [11:0] ins(input logic [2:0] op, input logic [6:0] a);
    return {op, 2'b00, a};
  endfunction

  int checks = 0;
  int fails  = 0;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor
  logic mon_clr = 1'b0;
  int   cyc = 0;
  int   wr_count = 0;
  int   ev_n = 0;
  int   ev_bit [8];
  int   ev_cyc [8];
  logic [5:0] ev_sel [8];

  always @(negedge clk) begin
    cyc++;
    if (mon_clr) begin
      wr_count = 0;
      ev_n = 0;
    end else begin
      if (mem_we) wr_count++;
      for (int k = 0; k < 3; k++) begin
        if (io_pulse[k] && ev_n < 8) begin
          ev_bit[ev_n] = k;
          ev_cyc[ev_n] = cyc;
          ev_sel[ev_n] = io_sel;
          ev_n++;
        end
      end
    end
  end

  task automatic poke(input logic [7:0] a, input logic [11:0] d);
    @(negedge clk);
    tb_addr = a; tb_data = d; tb_we = 1'b1;
    @(negedge clk);
    tb_we = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic clear_mon();
    @(posedge clk); mon_clr = 1'b1;
    @(posedge clk); mon_clr = 1'b0;
  endtask

  logic [11:0] pc_after_start;
  logic        run_after_start;

  task automatic run_from(input logic [11:0] a);
    int n;
    @(negedge clk);
    start = 1'b1; start_addr = a;
    @(negedge clk);
    start = 1'b0;
    pc_after_start = pc_o;
    run_after_start = run_o;
    n = 0;
    while (run_o && n < 1000) begin
      @(negedge clk);
      n++;
    end
    if (n >= 1000) chk("R11 halt reached", 16'd0, 16'd1);
    @(posedge clk);
    @(negedge clk);
  endtask

  logic [11:0] vals [8] = '{12'h000, 12'h001, 12'h7FF, 12'h800, 12'hFFF, 12'h555, 12'hAAA, 12'hFFE};

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [12:0] s;
    logic [11:0] x1;
    do_reset();
    // R1 reset state
    chk("R1 run", {15'd0, run_o}, 16'd0);
    chk("R1 pc", {4'd0, pc_o}, 16'd0);
    chk("R1 ac", {4'd0, ac_o}, 16'd0);
    chk("R1 link", {15'd0, link_o}, 16'd0);
    clear_mon();
    repeat (6) @(negedge clk);
    chk("R1 idle pc", {4'd0, pc_o}, 16'd0);
    chk("R1 idle writes", 16'(wr_count), 16'd0);

    // R5 add sweep, R3 pc after halt
    poke(0, ins(3'd1, 7'h40)); poke(1, ins(3'd1, 7'h41)); poke(2, W_HALT);
    for (int i = 0; i < 8; i++) begin
      for (int j = 0; j < 8; j++) begin
        poke(8'h40, vals[i]); poke(8'h41, vals[j]);
        do_reset();
        run_from(12'd0);
        s = {1'b0, vals[i]} + {1'b0, vals[j]};
        chk("R5 add link:ac", {3'd0, link_o, ac_o}, {3'd0, s});
        chk("R3 pc after halt", {4'd0, pc_o}, 16'd3);
      end
    end

    // R2 start loads pc and sets run
    chk("R2 start pc", {4'd0, pc_after_start}, 16'd0);
    chk("R2 start run", {15'd0, run_after_start}, 16'd1);

    // R4 and sweep
    poke(1, ins(3'd0, 7'h41));
    for (int i = 0; i < 8; i++) begin
      for (int j = 0; j < 8; j++) begin
        poke(8'h40, vals[i]); poke(8'h41, vals[j]);
        do_reset();
        run_from(12'd0);
        chk("R4 and ac", {4'd0, ac_o}, {4'd0, vals[i] & vals[j]});
        chk("R4 and link", {15'd0, link_o}, 16'd0);
      end
    end

    // R6 increment and skip on zero
    poke(0, ins(3'd2, 7'h40)); poke(1, ins(3'd1, 7'h41)); poke(2, W_HALT);
    poke(8'h41, 12'h123);
    for (int i = 0; i < 8; i++) begin
      poke(8'h40, vals[i]);
      do_reset();
      run_from(12'd0);
      x1 = vals[i] + 12'd1;
      chk("R6 mem incremented", {4'd0, mem[8'h40]}, {4'd0, x1});
      chk("R6 skip marker", {4'd0, ac_o}, (x1 == 12'd0) ? 16'd0 : 16'h123);
    end

    // R7 deposit and clear, R12 single write
    poke(0, ins(3'd1, 7'h40)); poke(1, ins(3'd3, 7'h42)); poke(2, W_HALT);
    poke(8'h40, 12'hB6D); poke(8'h42, 12'h000);
    do_reset();
    clear_mon();
    run_from(12'd0);
    chk("R7 stored", {4'd0, mem[8'h42]}, 16'hB6D);
    chk("R7 ac cleared", {4'd0, ac_o}, 16'd0);
    chk("R12 write count", 16'(wr_count), 16'd1);

    // R8 subroutine call
    poke(0, ins(3'd4, 7'h50)); poke(8'h50, 12'hABC); poke(8'h51, W_HALT);
    do_reset();
    clear_mon();
    run_from(12'd0);
    chk("R8 return addr", {4'd0, mem[8'h50]}, 16'd1);
    chk("R8 pc", {4'd0, pc_o}, 16'h52);
    chk("R12 call writes", 16'(wr_count), 16'd1);

    // R9 jump
    poke(0, ins(3'd5, 7'h60)); poke(1, ins(3'd1, 7'h41)); poke(8'h60, W_HALT);
    do_reset();
    clear_mon();
    run_from(12'd0);
    chk("R9 pc", {4'd0, pc_o}, 16'h61);
    chk("R9 ac untouched", {4'd0, ac_o}, 16'd0);
    chk("R9 no write", 16'(wr_count), 16'd0);

    // R10 pulse patterns
    poke(1, W_HALT);
    for (int p = 0; p < 8; p++) begin
      poke(0, {3'd6, 6'h2D, 3'(p)});
      do_reset();
      clear_mon();
      run_from(12'd0);
      chk("R10 pulse count", 16'(ev_n), 16'($countones(3'(p))));
      for (int e = 0; e < ev_n; e++) begin
        chk("R10 pulse enabled", {15'd0, p[ev_bit[e]]}, 16'd1);
        chk("R10 select", {10'd0, ev_sel[e]}, 16'h2D);
        if (e > 0) begin
          chk("R10 order", 16'(ev_bit[e] > ev_bit[e-1]), 16'd1);
          chk("R10 spacing", 16'(ev_cyc[e] - ev_cyc[0]), 16'(ev_bit[e] - ev_bit[0]));
        end
      end
    end

    // R11 operate skip and halt, then R2 restart without reset
    poke(0, ins(3'd1, 7'h40)); poke(1, W_SKIP); poke(2, W_CLA); poke(3, W_HALT);
    poke(8'h40, 12'h321);
    poke(8'h10, W_CLA); poke(8'h11, W_HALT);
    do_reset();
    run_from(12'd0);
    chk("R11 skip kept ac", {4'd0, ac_o}, 16'h321);
    chk("R11 pc", {4'd0, pc_o}, 16'd4);
    chk("R11 run cleared", {15'd0, run_o}, 16'd0);
    run_from(12'h010);
    chk("R2 restart pc", {4'd0, pc_after_start}, 16'h010);
    chk("R11 clear ac", {4'd0, ac_o}, 16'd0);
    chk("R11 pc restart", {4'd0, pc_o}, 16'h012);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule